// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block sits between an internal single-word request bus and an external asynchronous static RAM of 128K 16-bit words. Each accepted request becomes a fixed sequence of active-low strobes. These are chip select, output enable, write strobe and separate upper and lower byte-lane enables. The sequence holds a stable address on the memory pins. The bidirectional data bus appears as three vectors: a driven value, a sampled value and a per-bit drive enable.

Every phase length is a whole number of clock cycles. Each length is the ceiling of a nanosecond figure divided by the clock period, and is never less than one cycle. A read holds the strobes for the access time and samples the data on the edge that ends that window. The block then waits out the bus release time before it takes the next request. A write holds every strobe low together for a window that covers the strobe, address, byte-lane and data setup minimums. It then adds hold cycles so that the cycle-time minimum is met. A request with no byte lane selected completes without touching the memory.

Top module: `sram16_async_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all five strobes are high, `mem_dout_en` is zero, `rsp_valid` is low and `req_ready` is high.
- R2: A read with a non-zero lane mask holds chip select and output enable low, with the write strobe high, for RD_CYC = max(ceil(55/P), ceil(25/P), 1) cycles. This is 6 cycles at P = 10 ns. The upper lane enable is low exactly when mask bit 1 is set, and the lower lane enable is low exactly when mask bit 0 is set.
- R3: A read's data is sampled on the edge that ends its strobe window. On the next cycle `rsp_valid` is high for exactly one cycle, and `rsp_rdata` bits 15:8 and 7:0 hold the sampled lanes. Any lane not selected reads as zero.
- R4: A write with a non-zero mask holds chip select and the write strobe low, with output enable high, for WP_CYC = ceil(max(40,45,50,25)/P) cycles. This is 5 cycles at P = 10 ns. The lane enables follow the mask as in R2.
- R5: After the write window, all strobes are high for max(ceil(55/P) − WP_CYC, 1) hold cycles, during which `req_ready` stays low. This is 1 cycle at P = 10 ns.
- R6: `mem_dout_en` bits 15:8 and 7:0 are each driven only for a selected lane. They are set only during the write window and the first hold cycle, and never while output enable is low. `mem_dout` then carries the request data.
- R7: After a read ends, `req_ready` stays low for ceil(20/P) cycles. This is 2 cycles at P = 10 ns.
- R8: A read with mask 00 produces no strobe. On the next cycle `rsp_valid` is high, `rsp_rdata` is zero and `req_ready` is high.
- R9: A write with mask 00 produces no strobe, and it leaves the memory contents unchanged.
- R10: `mem_addr` equals the accepted request address and stays stable while chip select is low.
- R11: `req_ready` is high only when no strobe sequence or turnaround is in progress. While it is high, all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | 16 | Data driven toward memory |
| mem_din | input | 16 | Data sampled from memory |
| mem_dout_en | output | 16 | Per-bit drive enable for `mem_dout` |

## Verification
Two events can fall in the same cycle: the one-cycle response of a read with mask 00, and the acceptance of the next request. The bench issues a masked read and, in the cycle where `rsp_valid` rises, presents a full read. It then requires `req_ready` high in that cycle, with zero read data and strobes that start on the following cycle. A second pairing is a write presented straight after a read. Here the bench requires the turnaround gap before the write strobes appear and before any data lane is driven.

// File: rtl/sram16_async_ctrl.sv
module sram16_async_ctrl #(
  parameter int ADDR_W          = 17,
  parameter int CLK_PERIOD_NS   = 10,
  parameter int T_ACCESS_NS     = 55,
  parameter int T_OE_ACCESS_NS  = 25,
  parameter int T_WE_MIN_NS     = 40,
  parameter int T_ADDR_SETUP_NS = 45,
  parameter int T_LANE_MIN_NS   = 50,
  parameter int T_DATA_SETUP_NS = 25,
  parameter int T_WCYCLE_NS     = 55,
  parameter int T_RELEASE_NS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dout,
  input  logic [15:0]       mem_din,
  output logic [15:0]       mem_dout_en
);

  function automatic int cyc(input int t_ns);
    int c;
    c = (t_ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = cyc(imax(T_ACCESS_NS, T_OE_ACCESS_NS));
  localparam int WP_CYC = cyc(imax(imax(T_WE_MIN_NS, T_ADDR_SETUP_NS),
                                   imax(T_LANE_MIN_NS, T_DATA_SETUP_NS)));
  localparam int WC_CYC = cyc(T_WCYCLE_NS);
  localparam int WH_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 1;
  localparam int TA_CYC = cyc(T_RELEASE_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(WH_CYC, TA_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_WHOLD} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [15:0]        wdata_q;
  logic [1:0]         be_q;
  logic               last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          if (req_be == 2'b00) begin
            if (!req_we) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
          end else if (req_we) begin
            state <= S_WR;
            cnt   <= CNT_W'(WP_CYC - 1);
          end else begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_CYC - 1);
          end
        end
        S_RD: if (last) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= {mem_din[15:8] & {8{be_q[1]}}, mem_din[7:0] & {8{be_q[0]}}};
          state     <= S_TURN;
          cnt       <= CNT_W'(TA_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_TURN: if (last) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_WR: if (last) begin
          state <= S_WHOLD;
          cnt   <= CNT_W'(WH_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WHOLD: if (last) state <= S_IDLE; else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic rd_act, wr_act, sel, drive;
  assign rd_act = (state == S_RD);
  assign wr_act = (state == S_WR);
  assign sel    = rd_act | wr_act;
  assign drive  = wr_act | (state == S_WHOLD && cnt == CNT_W'(WH_CYC - 1));

  assign req_ready   = (state == S_IDLE);
  assign mem_ce_n    = ~sel;
  assign mem_oe_n    = ~rd_act;
  assign mem_we_n    = ~wr_act;
  assign mem_ub_n    = ~(sel & be_q[1]);
  assign mem_lb_n    = ~(sel & be_q[0]);
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = {{8{drive & be_q[1]}}, {8{drive & be_q[0]}}};

endmodule

module sram16_async_ctrl_chk #(
  parameter int WP_CYC = 5,
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_dout_en
);
  logic [15:0] wlo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wlo <= '0;
    else if (mem_we_n) wlo <= '0;
    else if (wlo != 16'hFFFF) wlo <= wlo + 16'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (mem_ce_n && mem_oe_n && mem_we_n && mem_dout_en == '0);
    end
  end

  assert_read_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n && !mem_ce_n);
  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> wlo >= 16'(WP_CYC));
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dout_en != '0) |-> mem_oe_n);
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !req_ready);
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && mem_we_n && mem_oe_n);
endmodule

bind sram16_async_ctrl sram16_async_ctrl_chk #(.WP_CYC(WP_CYC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
  .mem_dout_en(mem_dout_en));

// File: tb/sram16_async_ctrl_tb.sv
module sram16_async_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_C = 6;
  localparam int WP_C = 5;
  localparam int WH_C = 1;
  localparam int TA_C = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_dout, mem_din, mem_dout_en;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [16:0] mem_addr;

  int errors = 0, checks = 0, cycles = 0;
  logic [15:0] sram [0:63];
  logic [15:0] model [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram16_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_dout_en(mem_dout_en));

  assign mem_din = (!mem_ce_n && !mem_oe_n && mem_we_n) ? sram[mem_addr[5:0]] : 16'hA5A5;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_lb_n && mem_dout_en[0]) sram[mem_addr[5:0]][7:0]  <= mem_dout[7:0];
      if (!mem_ub_n && mem_dout_en[8]) sram[mem_addr[5:0]][15:8] <= mem_dout[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [22:0] vec(input bit rdy, input bit rv, input bit ce, input bit oe,
                                      input bit we, input bit ub, input bit lb, input logic [15:0] den);
    return {rdy, rv, ce, oe, we, ub, lb, den};
  endfunction

  function automatic logic [22:0] now_vec();
    return {req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dout_en};
  endfunction

  function automatic logic [15:0] lanes(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic do_req(input bit we, input logic [16:0] a, input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] old, exp_rd;
    old = model.exists(a) ? model[a] : 16'h0000;
    exp_rd = old & lanes(be);
    chk("R11 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (be == 2'b00) begin
      if (we) chk("R9 masked write no strobe", 32'(now_vec()), 32'(vec(1,0,1,1,1,1,1,0)));
      else begin
        chk("R8 masked read response", 32'(now_vec()), 32'(vec(1,1,1,1,1,1,1,0)));
        chk("R8 masked read data", {16'd0, rsp_rdata}, 32'd0);
      end
    end else if (!we) begin
      for (int i = 0; i < RD_C; i++) begin
        chk("R2 read strobes", 32'(now_vec()), 32'(vec(0,0,0,0,1,!be[1],!be[0],0)));
        chk("R10 read address", {15'd0, mem_addr}, {15'd0, a});
        @(negedge clk);
      end
      chk("R3 read response strobes", 32'(now_vec()), 32'(vec(0,1,1,1,1,1,1,0)));
      chk("R3 read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
      for (int i = 1; i < TA_C; i++) begin
        @(negedge clk);
        chk("R7 turnaround", 32'(now_vec()), 32'(vec(0,0,1,1,1,1,1,0)));
      end
      @(negedge clk);
      chk("R7 ready after turnaround", 32'(now_vec()), 32'(vec(1,0,1,1,1,1,1,0)));
    end else begin
      for (int i = 0; i < WP_C; i++) begin
        chk("R4 write strobes", 32'(now_vec()), 32'(vec(0,0,0,1,0,!be[1],!be[0],lanes(be))));
        chk("R6 write data", {16'd0, mem_dout & lanes(be)}, {16'd0, wd & lanes(be)});
        chk("R10 write address", {15'd0, mem_addr}, {15'd0, a});
        @(negedge clk);
      end
      for (int i = 0; i < WH_C; i++) begin
        chk("R5 write hold", 32'(now_vec()), 32'(vec(0,0,1,1,1,1,1,(i == 0) ? lanes(be) : 16'h0)));
        @(negedge clk);
      end
      chk("R5 ready after write", 32'(now_vec()), 32'(vec(1,0,1,1,1,1,1,0)));
      model[a] = (old & ~lanes(be)) | (wd & lanes(be));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) sram[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 32'(now_vec()) & 32'h3FFFFF, 32'(vec(0,0,1,1,1,1,1,0)) & 32'h3FFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'(now_vec()), 32'(vec(1,0,1,1,1,1,1,0)));
    do_req(1, 17'h10003, 2'b11, 16'hBEEF);
    do_req(0, 17'h10003, 2'b11, 16'h0);
    do_req(0, 17'h10003, 2'b01, 16'h0);
    do_req(0, 17'h10003, 2'b10, 16'h0);
    do_req(1, 17'h00005, 2'b11, 16'h1234);
    do_req(1, 17'h00005, 2'b01, 16'hFF77);
    do_req(0, 17'h00005, 2'b11, 16'h0);
    do_req(1, 17'h00005, 2'b10, 16'h99AA);
    do_req(0, 17'h00005, 2'b11, 16'h0);
    do_req(1, 17'h00005, 2'b00, 16'hDEAD);
    do_req(0, 17'h00005, 2'b11, 16'h0);
    do_req(0, 17'h00005, 2'b00, 16'h0);
    do_req(0, 17'h10003, 2'b11, 16'h0);
    do_req(1, 17'h1FFFF, 2'b11, 16'h5A5A);
    do_req(1, 17'h00000, 2'b11, 16'h0F0F);
    do_req(0, 17'h1FFFF, 2'b11, 16'h0);
    do_req(0, 17'h00000, 2'b10, 16'h0);
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule